// File: doc/BRIEF.md
# Gated Ring-Oscillator Counter Bank

This block measures the speed of eight free-running ring oscillators, each made from a different kind of logic cell. Every oscillator clocks its own 12-bit counter. One gate pulse, generated in the reference clock domain, enables all eight counters at the same time. Its length in reference cycles comes from a 10-bit configuration input. Software can later divide each count by the gate length to get an oscillator frequency.

A measurement begins with a one-cycle `start` pulse. The gate is carried into each oscillator domain through a two-flop synchroniser. Each channel then returns its synchronised view of the gate, and the reference side synchronises that echo back. The block raises `done` only after every echo has fallen. From that point the counts are frozen and can be read through a registered channel-select port.

Top module: `rosc_counter_bank`

## Requirements
- R1: Each of the eight channels counts the rising edges of its own oscillator while its synchronised gate is high. After a measurement, a channel with oscillator period P reads within 2 of len*Tref/P when that value is below 4095.
- R2: The gate rises on the clock edge that accepts `start`. It stays high for `cfg_len` reference cycles, where 0 counts as 1, and longer if some channel has not yet echoed the gate. So counts scale with the programmed length.
- R3: A counter holds at 0xFFF (4095) rather than wrapping. The channel's overflow flag is set when a count is lost this way, and it stays set until the next measurement.
- R4: Every accepted `start` clears all counts and overflow flags as the gate opens. A new measurement never adds to the previous one.
- R5: A `start` that arrives while `busy` is high is ignored. The `cfg_len` value captured when the measurement was accepted stays in force, even if `cfg_len` changes during the run.
- R6: `busy` goes high on the edge that accepts `start` and `done` goes low on that same edge. `done` rises and `busy` falls together once every channel confirms that the gate has closed. `done` then stays high until the next accepted `start`.
- R7: `rd_count` and `rd_ovf` show the count and overflow flag of the channel chosen by `rd_sel`, where value k selects channel k, one clock after `rd_sel` is applied. While `busy` is high they hold their value.
- R8: `rst` is synchronous and active-high. After reset, `busy`, `done`, `rd_count` and `rd_ovf` are 0 and every channel count reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset, reference domain |
| osc_clk | input | 8 | One free-running oscillator clock per channel |
| start | input | 1 | One-cycle measurement request |
| cfg_len | input | 10 | Gate length in reference cycles, captured at start |
| rd_sel | input | 3 | Channel to read back |
| rd_count | output | 12 | Frozen count of the selected channel |
| rd_ovf | output | 1 | Overflow flag of the selected channel |
| busy | output | 1 | Measurement in progress |
| done | output | 1 | Counts are stable and readable |

## Verification
The oscillators are modelled as eight clocks, with periods from 0.7 ns to 13.1 ns, that are not related to the reference clock. Gates of 20, 100 and 300 cycles show whether the counts follow the gate length and each oscillator's period, as opposed to a fixed offset or an off-by-one gate.

A full-scale 1023-cycle gate saturates only the fastest channel. This separates saturation from wrapping, and a short run afterwards shows whether the overflow flag and the count are cleared. A start request issued in the middle of a run, along with a changed length, shows whether the running measurement is really protected. A readback taken during that run checks that the output holds.

// File: rtl/rosc_pkg.sv
package rosc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_GATE  = 2'd1,
    ST_DRAIN = 2'd2
  } gate_state_t;
endpackage

// File: rtl/rosc_sync.sv
module rosc_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] st;

  always_ff @(posedge clk) begin
    if (rst) st <= '0;
    else     st <= {st[STAGES-2:0], d};
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/rosc_gate_timer.sv
module rosc_gate_timer
  import rosc_pkg::*;
#(
  parameter int LEN_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic             echo_all_hi,
  input  logic             echo_all_lo,
  output logic             gate,
  output logic             busy,
  output logic             done
);
  gate_state_t      state;
  logic [LEN_W-1:0] rem;
  logic [LEN_W-1:0] len_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      rem   <= '0;
      len_q <= '0;
      gate  <= 1'b0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            len_q <= cfg_len;
            rem   <= cfg_len;
            gate  <= 1'b1;
            busy  <= 1'b1;
            done  <= 1'b0;
            state <= ST_GATE;
          end
        end
        ST_GATE: begin
          if (rem > LEN_W'(1)) begin
            rem <= rem - LEN_W'(1);
          end else if (echo_all_hi) begin
            gate  <= 1'b0;
            state <= ST_DRAIN;
          end
        end
        ST_DRAIN: begin
          if (echo_all_lo) begin
            busy  <= 1'b0;
            done  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6: the gate never runs outside a measurement
  p_gate_in_busy_r6: assert property (@(posedge clk) disable iff (rst)
    gate |-> busy);
  // R6: done and busy are exclusive
  p_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R5: a start during a run leaves the captured length untouched
  p_start_ignored_r5: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(len_q));
  // R6: done only rises once the gate is closed
  p_done_after_close_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> !gate);
endmodule

// File: rtl/rosc_channel.sv
module rosc_channel #(
  parameter int CNT_W = 12
) (
  input  logic             osc_clk,
  input  logic             rst_ref,
  input  logic             gate_ref,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf,
  output logic             echo
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic rst_o;
  logic gate_s;
  logic gate_d;

  rosc_sync #(.W(1), .STAGES(2)) u_rst_sync (
    .clk(osc_clk), .rst(1'b0), .d(rst_ref), .q(rst_o)
  );

  rosc_sync #(.W(1), .STAGES(2)) u_gate_sync (
    .clk(osc_clk), .rst(rst_o), .d(gate_ref), .q(gate_s)
  );

  always_ff @(posedge osc_clk) begin
    if (rst_o) begin
      cnt    <= '0;
      ovf    <= 1'b0;
      gate_d <= 1'b0;
    end else begin
      gate_d <= gate_s;
      if (gate_s && !gate_d) begin
        cnt <= CNT_W'(1);
        ovf <= 1'b0;
      end else if (gate_s) begin
        if (cnt == CNT_MAX) ovf <= 1'b1;
        else                cnt <= cnt + CNT_W'(1);
      end
    end
  end

  assign echo = gate_s;

  // R3: a full counter holds and flags overflow
  p_no_overflow_r3: assert property (@(posedge osc_clk) disable iff (rst_o)
    (cnt == CNT_MAX && gate_s && gate_d) |=> (cnt == CNT_MAX && ovf));
  // R3: overflow stays set until the next gate opening
  p_ovf_sticky_r3: assert property (@(posedge osc_clk) disable iff (rst_o)
    (ovf && !(gate_s && !gate_d)) |=> ovf);
  // R4: the gate opening restarts the count
  p_clear_on_open_r4: assert property (@(posedge osc_clk) disable iff (rst_o)
    (gate_s && !gate_d) |=> (cnt == CNT_W'(1) && !ovf));
  // R1: with the gate low the count is frozen
  p_frozen_closed_r1: assert property (@(posedge osc_clk) disable iff (rst_o)
    (!gate_s && !gate_d) |=> $stable(cnt));
endmodule

// File: rtl/rosc_readback.sv
module rosc_readback #(
  parameter int N_CH  = 8,
  parameter int CNT_W = 12,
  parameter int SEL_W = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       busy,
  input  logic [SEL_W-1:0]           sel,
  input  logic [N_CH-1:0][CNT_W-1:0] cnt_all,
  input  logic [N_CH-1:0]            ovf_all,
  output logic [CNT_W-1:0]           rd_count,
  output logic                       rd_ovf
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_count <= '0;
      rd_ovf   <= 1'b0;
    end else if (!busy) begin
      if (int'(sel) < N_CH) begin
        rd_count <= cnt_all[sel];
        rd_ovf   <= ovf_all[sel];
      end else begin
        rd_count <= '0;
        rd_ovf   <= 1'b0;
      end
    end
  end

  // R7: readback holds during a measurement
  p_hold_busy_r7: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(rd_count) && $stable(rd_ovf)));
endmodule

// File: rtl/rosc_counter_bank.sv
module rosc_counter_bank #(
  parameter int N_CH  = 8,
  parameter int CNT_W = 12,
  parameter int LEN_W = 10,
  parameter int SEL_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_CH-1:0]  osc_clk,
  input  logic             start,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [CNT_W-1:0] rd_count,
  output logic             rd_ovf,
  output logic             busy,
  output logic             done
);
  logic                       gate;
  logic [N_CH-1:0][CNT_W-1:0] cnt_all;
  logic [N_CH-1:0]            ovf_all;
  logic [N_CH-1:0]            echo_osc;
  logic [N_CH-1:0]            echo_ref;

  rosc_gate_timer #(.LEN_W(LEN_W)) u_timer (
    .clk(clk), .rst(rst), .start(start), .cfg_len(cfg_len),
    .echo_all_hi(&echo_ref), .echo_all_lo(~|echo_ref),
    .gate(gate), .busy(busy), .done(done)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    rosc_channel #(.CNT_W(CNT_W)) u_ch (
      .osc_clk(osc_clk[i]), .rst_ref(rst), .gate_ref(gate),
      .cnt(cnt_all[i]), .ovf(ovf_all[i]), .echo(echo_osc[i])
    );
  end

  rosc_sync #(.W(N_CH), .STAGES(2)) u_echo_sync (
    .clk(clk), .rst(rst), .d(echo_osc), .q(echo_ref)
  );

  rosc_readback #(.N_CH(N_CH), .CNT_W(CNT_W), .SEL_W(SEL_W)) u_rd (
    .clk(clk), .rst(rst), .busy(busy), .sel(rd_sel),
    .cnt_all(cnt_all), .ovf_all(ovf_all),
    .rd_count(rd_count), .rd_ovf(rd_ovf)
  );
endmodule

// File: tb/rosc_counter_bank_tb.sv
`timescale 1ns/1ps
module rosc_counter_bank_tb;
  localparam int N_CH = 8;
  localparam real TREF = 4.0;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [N_CH-1:0] osc = '0;
  logic            start = 1'b0;
  logic [9:0]      cfg_len = '0;
  logic [2:0]      rd_sel = '0;
  logic [11:0]     rd_count;
  logic            rd_ovf, busy, done;

  int    checks = 0;
  int    errors = 0;
  bit    finished = 1'b0;
  longint cyc = 0;

  typedef struct {
    int     ch;
    int     exp;
    bit     sat;
    string  tag;
    longint due;
  } item_t;
  item_t sb[$];

  rosc_counter_bank u_dut (
    .clk(clk), .rst(rst), .osc_clk(osc), .start(start), .cfg_len(cfg_len),
    .rd_sel(rd_sel), .rd_count(rd_count), .rd_ovf(rd_ovf),
    .busy(busy), .done(done)
  );

  function automatic real per_ns(int i);
    case (i)
      0: return 0.7;  1: return 1.3;  2: return 2.9;  3: return 3.7;
      4: return 5.3;  5: return 7.1;  6: return 9.7;  default: return 13.1;
    endcase
  endfunction

  always #2 clk = ~clk;
  for (genvar g = 0; g < N_CH; g++) begin : g_osc
    always #(per_ns(g) / 2.0) osc[g] = ~osc[g];
  end

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: compares readback against queued expectations
  always @(negedge clk) begin
    if (sb.size() > 0 && cyc >= sb[0].due) begin
      item_t it;
      it = sb.pop_front();
      if (it.sat)
        check(rd_count == 12'hFFF && rd_ovf, {it.tag, " sat/ovf"},
              int'({rd_ovf, rd_count}), int'({1'b1, 12'hFFF}));
      else
        check((int'(rd_count) - it.exp <= 2) && (it.exp - int'(rd_count) <= 2) && !rd_ovf,
              it.tag, int'({rd_ovf, rd_count}), it.exp);
    end
  end

  task automatic push_reads(int len, string tag);
    for (int c = 0; c < N_CH; c++) begin
      item_t it;
      real   e;
      @(posedge clk); #1;
      rd_sel = 3'(c);
      e = real'(len) * TREF / per_ns(c);
      it.ch  = c;
      it.exp = int'(e);
      it.sat = (e >= 4095.0);
      it.tag = $sformatf("%s ch%0d", tag, c);
      it.due = cyc + 1;
      sb.push_back(it);
    end
    while (sb.size() > 0) @(posedge clk);
  endtask

  task automatic pulse_start(int len);
    @(posedge clk); #1;
    cfg_len = 10'(len);
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic run_meas(int len, string tag);
    pulse_start(len);
    check(busy && !done, "R6 busy after start", int'({busy, done}), 2);
    while (!done) @(posedge clk);
    #1;
    check(!busy && done, "R6 done at end", int'({busy, done}), 1);
    push_reads(len, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int     hold;
    longint t0;
    repeat (20) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R8 reset state
    check(!busy && !done, "R8 busy/done", int'({busy, done}), 0);
    check(rd_count == 0 && !rd_ovf, "R8 readback", int'(rd_count), 0);
    rd_sel = 3'd5;
    repeat (2) @(negedge clk);
    check(rd_count == 0, "R8 ch5 count", int'(rd_count), 0);

    run_meas(20, "R1");
    run_meas(100, "R2");
    run_meas(1023, "R3");
    run_meas(40, "R4");

    // R7 hold during busy, R5 start ignored while running
    @(posedge clk); #1 rd_sel = 3'd3;
    @(posedge clk); #1 hold = int'(rd_count);
    pulse_start(300);
    t0 = cyc;
    repeat (50) @(posedge clk);
    #1 rd_sel = 3'd0;
    cfg_len = 10'd10;
    start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    repeat (3) @(posedge clk);
    #1 check(int'(rd_count) == hold, "R7 hold while busy", int'(rd_count), hold);
    while (!done) @(posedge clk);
    #1 check(cyc - t0 >= 300, "R5 run length kept", int'(cyc - t0), 300);
    push_reads(300, "R5");

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule